// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Selector

This block gathers interrupt requests for a small 8-bit processor core and decides, every cycle, which one the core should take next. Level requests come from peripherals as pairs of a status flag and an enable bit. Several pairs may share one vector. Three further requests arrive as single-cycle pulses and are remembered until they are taken: a software trap, an illegal-opcode trap and a non-maskable line. The core supplies its two mask bits. The block presents a valid flag, the vector number and the vector fetch address.

When the core accepts the offered interrupt, the block asks the core to set the matching mask bit. The block then offers nothing for a fixed entry window while the core stacks its state. The level vectors are scanned in an order held in a small table. The core can rewrite one entry per cycle. A saturating counter records every raised or accepted request.

Top module: `irq_vec_ctrl`

## Requirements
- R1: A level vector is offered only while at least one source mapped to it has both flag and enable at 1. With flag or enable at 0 the source contributes nothing, and the offer drops on the next cycle.
- R2: Sources 0 to 3 all map to vector 10. Source k (k of 4 or more) maps to vector k+7, so source 14 maps to vector 21.
- R3: Pending trap requests ignore both mask bits. The software trap (vector 27) beats the illegal-opcode trap (vector 28). Each trap beats every other request, and each trap's pending state clears when it is accepted.
- R4: A pending non-maskable request (vector 26) is offered when the X mask input is 0. While it is pending with X at 1, nothing at all is offered, including level vectors. Its pending state clears when it is accepted.
- R5: While the I mask input is 1, no level vector is offered.
- R6: Level vectors are scanned in the order of a table of 32 vector numbers, and the first pending one wins. After reset, entry i holds vector i, so the lowest number wins. Writing entry 0 with vector 21 makes vector 21 win over vector 11.
- R7: Accepting a level vector does not clear it. If its flag is still set, it is offered again after the entry window.
- R8: The address output equals 0xFFC0 plus twice the vector output.
- R9: During a cycle in which the core accepts an offered interrupt, the X-set request is 1 for vector 26. For any other vector, the I-set request is 1 instead. The two requests are never 1 together.
- R10: After an acceptance the valid output stays 0 for 14 cycles. The next offer can appear on the 15th.
- R11: The counter adds one for each acceptance and one for each trap or non-maskable pulse in a cycle. It stops at its all-ones value.
- R12: When nothing is offered, valid is 0 and the vector output keeps its last offered value.
- R13: After reset, valid is 0, the vector output is 0, the counter is 0 and no trap request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_i | input | NUM_SRC | Peripheral status flags |
| enable_i | input | NUM_SRC | Peripheral enable bits |
| swi_req_i | input | 1 | Software trap pulse |
| ill_req_i | input | 1 | Illegal-opcode trap pulse |
| nmi_req_i | input | 1 | Non-maskable request pulse |
| imask_i | input | 1 | Core I mask bit |
| xmask_i | input | 1 | Core X mask bit |
| accept_i | input | 1 | Core takes the offered interrupt |
| ord_we_i | input | 1 | Priority table write strobe |
| ord_idx_i | input | VEC_W | Priority table entry to write |
| ord_vec_i | input | VEC_W | Vector number to store |
| irq_vld_o | output | 1 | An interrupt is offered |
| irq_vec_o | output | VEC_W | Offered vector number |
| irq_addr_o | output | ADDR_W | Vector fetch address |
| set_imask_o | output | 1 | Request to set the I mask |
| set_xmask_o | output | 1 | Request to set the X mask |
| raised_cnt_o | output | CNT_W | Saturating count of raised and accepted requests |

## Verification
The offer is registered. A change on the flags, enables, mask bits or priority table shows up at valid, vector and address one clock edge after it is applied. A trap pulse needs two edges: one to record it and one to offer it. The mask-set requests are combinational from the accept input, so the bench reads them a moment after raising accept, in the same cycle. The counter shows a pulse or an acceptance after the next edge. The bench drives every input at a falling edge and reads outputs at the falling edge on which a result is due. During the entry window it reads valid at each of the 14 falling edges after the acceptance edge and then expects the next offer at the 15th.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [2:0] {
      K_NONE,
      K_SWI,
      K_ILL,
      K_NMI,
      K_LVL
   } sel_kind_e;
endpackage

// File: rtl/irq_src_map.sv
module irq_src_map #(
   parameter int NUM_SRC       = 15,
   parameter int NUM_VEC       = 32,
   parameter int SHARED_SRCS   = 4,
   parameter int SHARED_VEC    = 10,
   parameter int FIRST_OWN_VEC = 11
) (
   input  logic [NUM_SRC-1:0] flag_i,
   input  logic [NUM_SRC-1:0] enable_i,
   output logic [NUM_VEC-1:0] vec_pend_o
);
   logic [NUM_SRC-1:0][NUM_VEC-1:0] hit;

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      localparam int VK = (k < SHARED_SRCS) ? SHARED_VEC : FIRST_OWN_VEC + k - SHARED_SRCS;
      assign hit[k] = (flag_i[k] & enable_i[k]) ? (NUM_VEC'(1) << VK) : '0;
   end

   always_comb begin
      vec_pend_o = '0;
      for (int k = 0; k < NUM_SRC; k++) vec_pend_o = vec_pend_o | hit[k];
   end
endmodule

// File: rtl/irq_order_arb.sv
module irq_order_arb
   import irq_pkg::*;
#(
   parameter int NUM_VEC = 32,
   parameter int VEC_W   = 5,
   parameter int SWI_VEC = 27,
   parameter int ILL_VEC = 28,
   parameter int NMI_VEC = 26
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ord_we_i,
   input  logic [VEC_W-1:0]   ord_idx_i,
   input  logic [VEC_W-1:0]   ord_vec_i,
   input  logic               swi_p_i,
   input  logic               ill_p_i,
   input  logic               nmi_p_i,
   input  logic               imask_i,
   input  logic               xmask_i,
   input  logic               blocked_i,
   input  logic [NUM_VEC-1:0] lvl_pend_i,
   output logic               sel_vld_o,
   output logic [VEC_W-1:0]   sel_vec_o
);
   localparam int VSPACE = 1 << VEC_W;

   logic [VEC_W-1:0]  ord_q [NUM_VEC];
   logic [VSPACE-1:0] lvl_ext;
   logic              lvl_found;
   logic [VEC_W-1:0]  lvl_vec;
   sel_kind_e         kind;

   assign lvl_ext = VSPACE'(lvl_pend_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_VEC; i++) ord_q[i] <= VEC_W'(i);
      end else if (ord_we_i && (int'(ord_idx_i) < NUM_VEC)) begin
         ord_q[ord_idx_i] <= ord_vec_i;
      end
   end

   always_comb begin
      lvl_found = 1'b0;
      lvl_vec   = '0;
      for (int i = 0; i < NUM_VEC; i++) begin
         if (!lvl_found && lvl_ext[ord_q[i]]) begin
            lvl_found = 1'b1;
            lvl_vec   = ord_q[i];
         end
      end
   end

   always_comb begin
      kind = K_NONE;
      if (blocked_i)      kind = K_NONE;
      else if (swi_p_i)   kind = K_SWI;
      else if (ill_p_i)   kind = K_ILL;
      else if (nmi_p_i)   kind = xmask_i ? K_NONE : K_NMI;
      else if (!imask_i && lvl_found) kind = K_LVL;
   end

   always_comb begin
      sel_vld_o = (kind != K_NONE);
      case (kind)
         K_SWI:   sel_vec_o = VEC_W'(SWI_VEC);
         K_ILL:   sel_vec_o = VEC_W'(ILL_VEC);
         K_NMI:   sel_vec_o = VEC_W'(NMI_VEC);
         K_LVL:   sel_vec_o = lvl_vec;
         default: sel_vec_o = '0;
      endcase
   end

   // R3: a pending software trap wins whenever the window is closed
   assert_swi_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (swi_p_i && !blocked_i) |-> (sel_vld_o && sel_vec_o == VEC_W'(SWI_VEC)));
   // R4: masked non-maskable request blocks all lower tiers
   assert_nmi_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_p_i && xmask_i && !swi_p_i && !ill_p_i) |-> !sel_vld_o);
   // R5: I mask hides level vectors
   assert_imask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (imask_i && !swi_p_i && !ill_p_i && !nmi_p_i) |-> !sel_vld_o);
endmodule

// File: rtl/irq_sat_cnt.sv
module irq_sat_cnt #(
   parameter int W    = 32,
   parameter int EV_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [EV_W-1:0] inc_i,
   output logic [W-1:0]    cnt_o
);
   logic [W:0] sum;

   assign sum = {1'b0, cnt_o} + (W+1)'(inc_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (sum[W]) cnt_o <= '1;
      else             cnt_o <= sum[W-1:0];
   end

   // R11: stays at the top once there
   assert_cnt_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o == '1) |=> (cnt_o == '1));
   // R11: every event below the top moves the count up
   assert_cnt_up_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i != '0 && cnt_o != '1) |=> (cnt_o > $past(cnt_o)));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
   parameter int          NUM_SRC       = 15,
   parameter int          VEC_W         = 5,
   parameter int          NUM_VEC       = 32,
   parameter int          SHARED_SRCS   = 4,
   parameter int          SHARED_VEC    = 10,
   parameter int          FIRST_OWN_VEC = 11,
   parameter int          NMI_VEC       = 26,
   parameter int          SWI_VEC       = 27,
   parameter int          ILL_VEC       = 28,
   parameter int          ADDR_W        = 16,
   parameter logic [15:0] VEC_BASE      = 16'hFFC0,
   parameter int          ENTRY_CYC     = 14,
   parameter int          CNT_W         = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] flag_i,
   input  logic [NUM_SRC-1:0] enable_i,
   input  logic               swi_req_i,
   input  logic               ill_req_i,
   input  logic               nmi_req_i,
   input  logic               imask_i,
   input  logic               xmask_i,
   input  logic               accept_i,
   input  logic               ord_we_i,
   input  logic [VEC_W-1:0]   ord_idx_i,
   input  logic [VEC_W-1:0]   ord_vec_i,
   output logic               irq_vld_o,
   output logic [VEC_W-1:0]   irq_vec_o,
   output logic [ADDR_W-1:0]  irq_addr_o,
   output logic               set_imask_o,
   output logic               set_xmask_o,
   output logic [CNT_W-1:0]   raised_cnt_o
);
   localparam int BW   = $clog2(ENTRY_CYC + 1);
   localparam int EV_W = 3;

   if (NUM_VEC > (1 << VEC_W)) begin : g_bad_vec_w
      $error("NUM_VEC does not fit in VEC_W bits");
   end
   if (FIRST_OWN_VEC + NUM_SRC - SHARED_SRCS > NUM_VEC) begin : g_bad_map
      $error("source map runs past NUM_VEC");
   end
   if (SWI_VEC >= NUM_VEC || ILL_VEC >= NUM_VEC || NMI_VEC >= NUM_VEC) begin : g_bad_trap
      $error("trap vector outside vector space");
   end
   if (ENTRY_CYC < 1) begin : g_bad_entry
      $error("ENTRY_CYC must be at least 1");
   end
   if (CNT_W < EV_W) begin : g_bad_cnt
      $error("CNT_W too narrow");
   end

   logic [NUM_VEC-1:0] lvl_pend;
   logic               swi_p, ill_p, nmi_p;
   logic [BW-1:0]      busy_q;
   logic               sel_vld;
   logic [VEC_W-1:0]   sel_vec;
   logic               taken;
   logic [EV_W-1:0]    events;

   assign taken = accept_i & irq_vld_o;

   irq_src_map #(
      .NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC), .SHARED_SRCS(SHARED_SRCS),
      .SHARED_VEC(SHARED_VEC), .FIRST_OWN_VEC(FIRST_OWN_VEC)
   ) u_map (
      .flag_i(flag_i), .enable_i(enable_i), .vec_pend_o(lvl_pend)
   );

   irq_order_arb #(
      .NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .SWI_VEC(SWI_VEC),
      .ILL_VEC(ILL_VEC), .NMI_VEC(NMI_VEC)
   ) u_arb (
      .clk(clk), .rst_n(rst_n), .ord_we_i(ord_we_i), .ord_idx_i(ord_idx_i),
      .ord_vec_i(ord_vec_i), .swi_p_i(swi_p), .ill_p_i(ill_p), .nmi_p_i(nmi_p),
      .imask_i(imask_i), .xmask_i(xmask_i), .blocked_i(busy_q != '0),
      .lvl_pend_i(lvl_pend), .sel_vld_o(sel_vld), .sel_vec_o(sel_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         swi_p <= 1'b0;
         ill_p <= 1'b0;
         nmi_p <= 1'b0;
      end else begin
         swi_p <= swi_req_i | (swi_p & ~(taken && irq_vec_o == VEC_W'(SWI_VEC)));
         ill_p <= ill_req_i | (ill_p & ~(taken && irq_vec_o == VEC_W'(ILL_VEC)));
         nmi_p <= nmi_req_i | (nmi_p & ~(taken && irq_vec_o == VEC_W'(NMI_VEC)));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= '0;
         irq_vld_o <= 1'b0;
         irq_vec_o <= '0;
      end else if (taken) begin
         busy_q    <= BW'(ENTRY_CYC - 1);
         irq_vld_o <= 1'b0;
      end else begin
         if (busy_q != '0) busy_q <= busy_q - 1'b1;
         irq_vld_o <= sel_vld;
         if (sel_vld) irq_vec_o <= sel_vec;
      end
   end

   assign irq_addr_o  = ADDR_W'(VEC_BASE) + (ADDR_W'(irq_vec_o) << 1);
   assign set_xmask_o = taken & (irq_vec_o == VEC_W'(NMI_VEC));
   assign set_imask_o = taken & (irq_vec_o != VEC_W'(NMI_VEC));

   assign events = EV_W'(taken) + EV_W'(swi_req_i) + EV_W'(ill_req_i) + EV_W'(nmi_req_i);

   irq_sat_cnt #(.W(CNT_W), .EV_W(EV_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc_i(events), .cnt_o(raised_cnt_o)
   );

   // R10: acceptance closes the offer for the entry window
   assert_accept_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
      taken |=> !irq_vld_o);
   assert_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q != '0) |=> !irq_vld_o);
   // R9: never both mask requests
   assert_mask_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({set_imask_o, set_xmask_o}));
   // R3: accepted software trap is forgotten
   assert_swi_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && irq_vec_o == VEC_W'(SWI_VEC) && !swi_req_i) |=> !swi_p);
   // R12: no offer keeps the vector output
   assert_vec_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_vld |=> $stable(irq_vec_o));
endmodule

// File: tb/sim_irq_vec_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vec_ctrl;
   localparam int NS = 15;
   localparam int CW = 5;

   typedef struct packed {
      logic [NS-1:0] flg;
      logic [NS-1:0] en;
      logic          ib;
      logic          xb;
      logic          ev;
      logic [4:0]    evec;
   } row_t;

   localparam row_t TBL [9] = '{
      '{15'h0001, 15'h0001, 1'b0, 1'b0, 1'b1, 5'd10},
      '{15'h0001, 15'h0000, 1'b0, 1'b0, 1'b0, 5'd10},
      '{15'h0004, 15'h0004, 1'b0, 1'b0, 1'b1, 5'd10},
      '{15'h0050, 15'h0050, 1'b0, 1'b0, 1'b1, 5'd11},
      '{15'h0050, 15'h0050, 1'b1, 1'b0, 1'b0, 5'd11},
      '{15'h0000, 15'h7FFF, 1'b0, 1'b0, 1'b0, 5'd11},
      '{15'h4000, 15'h4000, 1'b0, 1'b0, 1'b1, 5'd21},
      '{15'h4008, 15'h7FFF, 1'b0, 1'b0, 1'b1, 5'd10},
      '{15'h0002, 15'h0006, 1'b0, 1'b1, 1'b1, 5'd10}
   };

   logic clk = 0, rst_n = 0;
   logic [NS-1:0] flag_i = '0, enable_i = '0;
   logic swi = 0, ill = 0, nmi = 0, imask = 0, xmask = 0, accept = 0;
   logic ord_we = 0;
   logic [4:0] ord_idx = '0, ord_vec = '0;
   logic vld, set_i, set_x;
   logic [4:0] vec;
   logic [15:0] addr;
   logic [CW-1:0] cnt;

   int tests = 0, fails = 0, exp_cnt = 0;

   always #5 clk = ~clk;

   irq_vec_ctrl #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .enable_i(enable_i),
      .swi_req_i(swi), .ill_req_i(ill), .nmi_req_i(nmi), .imask_i(imask),
      .xmask_i(xmask), .accept_i(accept), .ord_we_i(ord_we), .ord_idx_i(ord_idx),
      .ord_vec_i(ord_vec), .irq_vld_o(vld), .irq_vec_o(vec), .irq_addr_o(addr),
      .set_imask_o(set_i), .set_xmask_o(set_x), .raised_cnt_o(cnt)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bump(input int n);
      exp_cnt = exp_cnt + n;
      if (exp_cnt > (1 << CW) - 1) exp_cnt = (1 << CW) - 1;
   endtask

   task automatic offer(input string req, input int v);
      chk({req, " valid"}, 32'(vld), 32'd1);
      chk({req, " vector"}, 32'(vec), 32'(v));
      chk("R8 address", 32'(addr), 32'(16'hFFC0 + 2 * v));
   endtask

   // accept at the current falling edge, then walk the entry window (R10)
   task automatic take(input logic ei, input logic ex);
      accept = 1;
      #1;
      chk("R9 set I", 32'(set_i), 32'(ei));
      chk("R9 set X", 32'(set_x), 32'(ex));
      @(negedge clk);
      accept = 0;
      bump(1);
      chk("R10 window", 32'(vld), 32'd0);
      for (int k = 0; k < 13; k++) begin
         @(negedge clk);
         chk("R10 window", 32'(vld), 32'd0);
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R13 valid", 32'(vld), 32'd0);
      chk("R13 vector", 32'(vec), 32'd0);
      chk("R13 count", 32'(cnt), 32'd0);
      chk("R8 reset address", 32'(addr), 32'h0000FFC0);
      rst_n = 1;
      @(negedge clk);
      chk("R13 idle after reset", 32'(vld), 32'd0);

      // table walk: R1 R2 R5 R6 R12
      for (int r = 0; r < 9; r++) begin
         flag_i = TBL[r].flg; enable_i = TBL[r].en;
         imask = TBL[r].ib; xmask = TBL[r].xb;
         @(negedge clk);
         chk("R1/R5 table valid", 32'(vld), 32'(TBL[r].ev));
         chk("R2/R6/R12 table vector", 32'(vec), 32'(TBL[r].evec));
         chk("R8 table address", 32'(addr), 32'(16'hFFC0 + 2 * TBL[r].evec));
      end
      xmask = 0;

      // R6 programmed order
      ord_we = 1; ord_idx = 5'd0; ord_vec = 5'd21;
      @(negedge clk);
      ord_we = 0; flag_i = 15'h4010; enable_i = 15'h7FFF;
      @(negedge clk);
      offer("R6 programmed order", 21);
      ord_we = 1; ord_idx = 5'd0; ord_vec = 5'd0;
      @(negedge clk);
      ord_we = 0;
      @(negedge clk);
      offer("R6 restored order", 11);

      // traps beat masks: R3
      flag_i = 15'h0001; enable_i = 15'h0001; imask = 1; xmask = 1;
      swi = 1; ill = 1; nmi = 1;
      @(negedge clk);
      swi = 0; ill = 0; nmi = 0;
      bump(3);
      @(negedge clk);
      offer("R3 software trap first", 27);
      chk("R11 pulses counted", 32'(cnt), 32'(exp_cnt));
      take(1'b1, 1'b0);
      offer("R3 illegal after software", 28);
      take(1'b1, 1'b0);
      // R4 masked non-maskable blocks level vector even with I clear
      imask = 0;
      @(negedge clk);
      chk("R4 masked nmi blocks all", 32'(vld), 32'd0);
      xmask = 0;
      @(negedge clk);
      offer("R4 nmi offered", 26);
      take(1'b0, 1'b1);
      xmask = 1;
      @(negedge clk);
      offer("R4 nmi cleared level next", 10);
      take(1'b1, 1'b0);
      offer("R7 level offered again", 10);
      chk("R11 accepts counted", 32'(cnt), 32'(exp_cnt));
      flag_i = '0;
      @(negedge clk);
      chk("R1 offer drops", 32'(vld), 32'd0);
      chk("R12 vector held", 32'(vec), 32'd10);

      // R11 saturation
      imask = 1;
      swi = 1;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         bump(1);
      end
      swi = 0;
      chk("R11 saturated", 32'(cnt), 32'(exp_cnt));
      @(negedge clk);
      chk("R11 stays saturated", 32'(cnt), 32'((1 << CW) - 1));

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule